// File: doc/BRIEF.md
# Rising-Edge Phase/Frequency Detector

This block compares the rising edges of two slow clocks: a locally generated word clock and an external reference clock. It drives two correction outputs, `up_o` and `dn_o`, for an external loop integrator. `up_o` goes high when the word clock rises first. `dn_o` goes high when the reference rises first. In each case the output stays high until the lagging clock rises. The width of the pulse therefore tracks the phase error.

A fast oversampling clock samples both slow clocks through a synchroniser chain of `SYNC_STAGES` flops. Rising edges are found on the synchronised samples. The block measures pulse widths in whole oversampling cycles. Its core is a pair of set-reset latches that share one state register. A rising edge first clears the opposite latch if that latch is set. Only otherwise does it set its own latch, so at most one output is high at any time. Falling edges of either clock have no effect.

Top module: `rise_pfd`

## Requirements
- R1: A synchronous active-high `rst` sampled on a `clk` edge forces both `up_o` and `dn_o` low after that edge and clears any pending pulse.
- R2: If the word clock is first sampled high N oversampling cycles (N ≥ 1) before the reference, `up_o` is high for exactly N consecutive cycles and `dn_o` stays low.
- R3: If the reference clock is first sampled high N cycles (N ≥ 1) before the word clock, `dn_o` is high for exactly N consecutive cycles and `up_o` stays low.
- R4: If both rising edges are sampled in the same oversampling cycle, neither output is asserted.
- R5: A falling edge of either input changes neither output. This holds both while a pulse is in progress and while the block is idle.
- R6: The rising edge of the lagging clock ends the pending pulse and does not start a pulse on the other output. `up_o` and `dn_o` are never high together.
- R7: An output rises on the (SYNC_STAGES+1)-th `clk` edge counted from the first edge at which its leading input is sampled high. With the default of 2 stages, that is the 3rd edge.
- R8: Further rising edges of the leading clock while its output is already high neither end nor restart the pulse. The width is counted from the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Word clock, asynchronous to `clk` |
| rclk_i | input | 1 | Reference clock, asynchronous to `clk` |
| up_o | output | 1 | High while the word clock leads the reference |
| dn_o | output | 1 | High while the reference leads the word clock |

## Verification
The assertions assume that each input holds for at least one full oversampling cycle between transitions, so the synchroniser never sees a glitch narrower than a sample. They also assume that a leading edge is always followed by its partner before the next leading edge of the other clock. The bench changes both inputs only on falling edges of `clk` and holds every level for one or more whole cycles. Every phase error is therefore an exact number of cycles, and the expected pulse width is known in advance. Edge pairs are separated by idle gaps longer than the synchroniser depth, so the latch state from one pair cannot leak into the next.

// File: rtl/rpfd_pkg.sv
package rpfd_pkg;

    localparam int unsigned NUM_CLKS = 2;

    // Rising-edge flags for the two compared clocks
    typedef struct packed {
        logic wclk;
        logic rclk;
    } pair_t;

    // Shared latch state: at most one side pending
    typedef enum logic [1:0] {
        PD_IDLE = 2'b00,
        PD_UP   = 2'b01,
        PD_DN   = 2'b10
    } pd_state_e;

    // An edge first cancels the opposite pending pulse, otherwise sets its own
    function automatic pd_state_e pd_next(pd_state_e cur, pair_t rise);
        pd_state_e nxt;
        nxt = cur;
        if (rise.wclk && rise.rclk) begin
            nxt = PD_IDLE;
        end else if (rise.wclk) begin
            nxt = (cur == PD_DN) ? PD_IDLE : PD_UP;
        end else if (rise.rclk) begin
            nxt = (cur == PD_UP) ? PD_IDLE : PD_DN;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/rpfd_sync.sv
module rpfd_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][N-1:0] stg;
    logic [N-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= '0;
            prev <= '0;
        end else begin
            stg  <= {stg[STAGES-2:0], din};
            prev <= stg[LAST];
        end
    end

    assign rise = stg[LAST] & ~prev;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            // R5: only a low-to-high change yields an edge, one cycle long
            p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
                rise[i] |=> !rise[i]);
        end
    endgenerate

endmodule

// File: rtl/rpfd_latch.sv
module rpfd_latch
    import rpfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t rise,
    output logic  up_o,
    output logic  dn_o
);
    pd_state_e state;

    always_ff @(posedge clk) begin
        if (rst) state <= PD_IDLE;
        else     state <= pd_next(state, rise);
    end

    assign up_o = (state == PD_UP);
    assign dn_o = (state == PD_DN);

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        !(up_o && dn_o));
    p_up_set_r2: assert property (@(posedge clk) disable iff (rst)
        (rise.wclk && !rise.rclk && !dn_o) |=> up_o);
    p_dn_set_r3: assert property (@(posedge clk) disable iff (rst)
        (rise.rclk && !rise.wclk && !up_o) |=> dn_o);
    p_pair_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rise.rclk && !rise.wclk && up_o) |=> (!up_o && !dn_o));
    p_coincident_r4: assert property (@(posedge clk) disable iff (rst)
        (rise.wclk && rise.rclk) |=> (!up_o && !dn_o));
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!rise.wclk && !rise.rclk) |=> ($stable(up_o) && $stable(dn_o)));

endmodule

// File: rtl/rise_pfd.sv
module rise_pfd
    import rpfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wclk_i,
    input  logic rclk_i,
    output logic up_o,
    output logic dn_o
);
    logic [NUM_CLKS-1:0] rise_vec;
    pair_t               rise;

    rpfd_sync #(
        .N      (NUM_CLKS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({wclk_i, rclk_i}),
        .rise (rise_vec)
    );

    assign rise = pair_t'(rise_vec);

    rpfd_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .up_o (up_o),
        .dn_o (dn_o)
    );

    // R1: reset leaves both outputs low after the edge
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (!up_o && !dn_o));

endmodule

// File: tb/rise_pfd_bench.sv
`timescale 1ns/1ps
module rise_pfd_bench;
    localparam int STAGES = 2;
    localparam int LAT    = STAGES + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic up, dn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int pulses = 0;
    int overlap = 0;

    typedef struct {
        bit    is_up;
        int    width;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    rise_pfd #(.SYNC_STAGES(STAGES)) u_rise_pfd (
        .clk(clk), .rst(rst), .wclk_i(wclk), .rclk_i(rclk),
        .up_o(up), .dn_o(dn)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Monitor: measure each completed pulse and compare with the queue head
    task automatic close_pulse(bit is_up, int width);
        exp_t e;
        pulses++;
        if (q.size() == 0) begin
            check(1'b0, is_up ? "R6 unexpected up pulse" : "R6 unexpected dn pulse", width, 0);
        end else begin
            e = q.pop_front();
            check(e.is_up == is_up, {e.tag, " side"}, int'(is_up), int'(e.is_up));
            check(e.width == width, {e.tag, " width"}, width, e.width);
        end
    endtask

    int up_cnt = 0;
    int dn_cnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            up_cnt = 0;
            dn_cnt = 0;
        end else begin
            if (up && dn) overlap++;
            if (up) up_cnt++;
            else if (up_cnt > 0) begin close_pulse(1'b1, up_cnt); up_cnt = 0; end
            if (dn) dn_cnt++;
            else if (dn_cnt > 0) begin close_pulse(1'b0, dn_cnt); dn_cnt = 0; end
        end
    end

    // Driver: leader rises, n cycles later the other, then both fall
    task automatic edge_pair(bit word_first, int n, string tag);
        exp_t e;
        if (n > 0) begin
            e.is_up = word_first; e.width = n; e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        if (n == 0) begin wclk = 1'b1; rclk = 1'b1; end
        else if (word_first) wclk = 1'b1;
        else rclk = 1'b1;
        repeat (n) @(negedge clk);
        wclk = 1'b1; rclk = 1'b1;
        repeat (6) @(negedge clk);
        wclk = 1'b0; rclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int p0;
        exp_t e;
        repeat (3) @(negedge clk);
        check(!up && !dn, "R1 reset state", int'({up, dn}), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R7: latency from first high sample
        e.is_up = 1'b1; e.width = 4; e.tag = "R7";
        q.push_back(e);
        wclk = 1'b1;
        repeat (LAT - 1) @(negedge clk);
        check(!up, "R7 before latency", int'(up), 0);
        @(negedge clk);
        check(up, "R7 at latency", int'(up), 1);
        repeat (4 - LAT) @(negedge clk);
        rclk = 1'b1;
        repeat (8) @(negedge clk);
        wclk = 1'b0; rclk = 1'b0;
        repeat (8) @(negedge clk);

        // R2 / R3: various leads
        edge_pair(1'b1, 1,  "R2 lead1");
        edge_pair(1'b1, 3,  "R2 lead3");
        edge_pair(1'b1, 7,  "R2 lead7");
        edge_pair(1'b0, 2,  "R3 lead2");
        edge_pair(1'b0, 5,  "R3 lead5");
        edge_pair(1'b0, 12, "R3 lead12");

        // R4: coincident edges
        p0 = pulses;
        edge_pair(1'b1, 0, "R4");
        edge_pair(1'b0, 0, "R4");
        check(pulses == p0 && !up && !dn, "R4 no pulse", pulses - p0, 0);

        // R5: word falls during its own pulse
        e.is_up = 1'b1; e.width = 5; e.tag = "R5 fall mid-pulse";
        q.push_back(e);
        wclk = 1'b1;
        repeat (2) @(negedge clk);
        wclk = 1'b0;
        repeat (3) @(negedge clk);
        rclk = 1'b1;
        repeat (8) @(negedge clk);
        rclk = 1'b0;
        repeat (8) @(negedge clk);

        // R5: lone falling edges from an in-phase high state
        wclk = 1'b1; rclk = 1'b1;
        repeat (8) @(negedge clk);
        p0 = pulses;
        wclk = 1'b0;
        repeat (6) @(negedge clk);
        check(!up && !dn, "R5 word fall idle", int'({up, dn}), 0);
        rclk = 1'b0;
        repeat (6) @(negedge clk);
        check(pulses == p0 && !up && !dn, "R5 ref fall idle", pulses - p0, 0);

        // R8: repeated word edge while up pending
        e.is_up = 1'b1; e.width = 7; e.tag = "R8";
        q.push_back(e);
        wclk = 1'b1;
        repeat (2) @(negedge clk);
        wclk = 1'b0;
        repeat (2) @(negedge clk);
        wclk = 1'b1;
        repeat (3) @(negedge clk);
        rclk = 1'b1;
        repeat (8) @(negedge clk);
        wclk = 1'b0; rclk = 1'b0;
        repeat (8) @(negedge clk);

        // R1: reset in the middle of a pulse
        wclk = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1; wclk = 1'b0;
        @(negedge clk);
        check(!up && !dn, "R1 reset mid-pulse", int'({up, dn}), 0);
        @(negedge clk);
        rst = 1'b0;
        p0 = pulses;
        repeat (10) @(negedge clk);
        check(pulses == p0 && !up && !dn, "R1 quiet after reset", pulses - p0, 0);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2 all expected pulses seen", q.size(), 0);
        check(overlap == 0, "R6 outputs never both high", overlap, 0);
        report();
    end

endmodule